// File: doc/BRIEF.md
# Card Interrupt Steering Router

This block takes the interrupt and status-change lines of two card sockets and steers them onto host interrupt outputs: two PCI-style interrupt lines (A and B), a bank of sixteen ISA-style IRQ lines, a power-management event line and a ring-indicate line. All outputs are active-low and registered. Software sets the routing through a small write-only register port. Each socket has one configuration word, and there is one global word and one write-one-to-clear status word.

A socket's card interrupt is a level request that is active low. Its route field sends it to PCI line A, to PCI line B, to one selected ISA line, or nowhere. When several sockets land on the same output, that output shows the OR of their requests. A rising edge on a socket's status-change input sets a sticky flag, which can raise the event output. A socket enabled for ring detection instead passes its status-change level to the ring-indicate output. That output is further gated by a global ring enable and a global inhibit bit.

Register map: address s (s < socket count) is socket s's configuration word. The bits of that word are:

| Bits | Field | Meaning |
|---|---|---|
| [1:0] | route | 0 = off, 1 = PCI A, 2 = PCI B, 3 = ISA |
| [5:2] | ISA line number | selects one of the sixteen ISA lines |
| [6] | wake enable | sticky flag may raise the event output |
| [7] | ring enable | status-change level feeds ring indicate |
| [8] | power qualifier | second per-socket condition for ring indicate |

Address 2 is the global word: bit 0 selects the ISA mode (1 = PCI+ISA, 0 = PCI only), bit 1 is the ring master enable, and bit 2 is the ring inhibit. Address 3 is the write-one-to-clear word for the sticky flags: bit s clears socket s.

Top module: `card_irq_router`

## Requirements
- R1: After reset, inta_n, intb_n, pme_n and ring_n are 1, every isa_irq_n bit is 1, all configuration is zero and no sticky flag is set.
- R2: A socket with route 1 (PCI A) or route 2 (PCI B) whose card_irq_n is 0 drives the matching PCI line to 0 one clock after it is sampled. The line returns to 1 one clock after the request is released.
- R3: In PCI+ISA mode (global bit 0 = 1), a socket with route 3 drives isa_irq_n[n] low, where n is its ISA line number in bits [5:2]. No other ISA line is driven, and neither PCI line is driven.
- R4: A socket with route 0 reaches no output.
- R5: When two sockets steer to the same output, that output is low whenever either of their requests is active.
- R6: In PCI-only mode (global bit 0 = 0), a socket with route 3 drives no output.
- R7: A rising edge on stschg[s] sets socket s's sticky flag. The flag stays set until a write of 1 to bit s of address 3, and a write of 0 leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R8: pme_n is 0 one clock after any socket has both its sticky flag set and its wake-enable bit (bit 6) set, which is two clocks after the stschg edge.
- R9: ring_n is 0 one clock after a cycle in which some socket has stschg at 1, ring enable (bit 7) at 1 and the power qualifier (bit 8) at 1, while the global ring master enable (bit 1) is 1 and the global inhibit bit (bit 2) is 0.
- R10: A status-change edge on a socket with ring enable set does not set that socket's sticky flag, so it cannot raise pme_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| card_irq_n | input | 2 | Card interrupt per socket, active low, level |
| stschg | input | 2 | Status-change / ring input per socket, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 9 | Register write data |
| inta_n | output | 1 | PCI interrupt line A, active low |
| intb_n | output | 1 | PCI interrupt line B, active low |
| isa_irq_n | output | 16 | ISA IRQ lines, active low |
| pme_n | output | 1 | Power-management event, active low |
| ring_n | output | 1 | Ring indicate, active low |

## Verification
Interrupt routing and ring indicate each pass through one output register, so they are due one clock after the inputs are sampled. The event output sits behind the sticky flag plus its own register and is due two clocks after the status-change edge. A register write takes effect on its own edge, so any output it changes is due one clock later. The bench applies each stimulus at a falling edge, advances exactly the number of rising edges listed for that result, and samples at the next falling edge. The sticky cases also hold the input idle for several more cycles before re-sampling, to show that the flag persists.

// File: rtl/card_irq_pkg.sv
// Package: shared types and sizes for the card interrupt router.
// Assumes the per-socket configuration word layout is fixed by the struct below.
package card_irq_pkg;
    localparam int ISA_LINES = 16;
    localparam int ISA_SEL_W = $clog2(ISA_LINES);

    typedef enum logic [1:0] {
        RT_OFF  = 2'd0,
        RT_PCIA = 2'd1,
        RT_PCIB = 2'd2,
        RT_ISA  = 2'd3
    } route_e;

    typedef struct packed {
        logic                 pwr_ok;
        logic                 ring_en;
        logic                 wake_en;
        logic [ISA_SEL_W-1:0] isa_sel;
        route_e               route;
    } sock_cfg_t;

    localparam int CFG_W = $bits(sock_cfg_t);
endpackage

// File: rtl/cir_regs.sv
// Register file: per-socket configuration words, one global word, and a
// write-one-to-clear strobe for the sticky flags. Write-only, no read path.
// Assumes addresses 0..NUM_SOCK-1 are socket words, NUM_SOCK is the global
// word and NUM_SOCK+1 is the clear word.
module cir_regs
    import card_irq_pkg::*;
#(
    parameter int NUM_SOCK = 2,
    parameter int ADDR_W   = $clog2(NUM_SOCK + 2)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [CFG_W-1:0]                 reg_wdata,
    output sock_cfg_t [NUM_SOCK-1:0]         cfg,
    output logic                             isa_mode,
    output logic                             ring_master,
    output logic                             ring_inhibit,
    output logic [NUM_SOCK-1:0]              clr
);
    localparam logic [ADDR_W-1:0] GLB_ADDR = ADDR_W'(NUM_SOCK);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_SOCK + 1);

    logic [2:0] glb_q;

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_cfg
        // Hold socket s's configuration word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg[s] <= '0;
            else if (reg_we && reg_addr == ADDR_W'(s))
                cfg[s] <= sock_cfg_t'(reg_wdata);
        end
    end

    // Hold the global mode / ring gating word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            glb_q <= '0;
        else if (reg_we && reg_addr == GLB_ADDR)
            glb_q <= reg_wdata[2:0];
    end

    // Produce the one-cycle clear strobe for the sticky flags.
    always_comb begin
        clr = '0;
        if (reg_we && reg_addr == CLR_ADDR)
            clr = reg_wdata[NUM_SOCK-1:0];
    end

    assign isa_mode     = glb_q[0];
    assign ring_master  = glb_q[1];
    assign ring_inhibit = glb_q[2];
endmodule

// File: rtl/cir_status.sv
// Status-change handling: per-socket edge detection into sticky flags and
// the registered ring-indicate output. Assumes stschg is already synchronous.
module cir_status
    import card_irq_pkg::*;
#(
    parameter int NUM_SOCK = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SOCK-1:0]      stschg,
    input  sock_cfg_t [NUM_SOCK-1:0] cfg,
    input  logic [NUM_SOCK-1:0]      clr,
    input  logic                     ring_master,
    input  logic                     ring_inhibit,
    output logic [NUM_SOCK-1:0]      flag,
    output logic                     ring_n
);
    logic [NUM_SOCK-1:0] prev_q;
    logic [NUM_SOCK-1:0] ring_src;

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        // Track the previous input level and keep the sticky flag (set wins).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[s] <= 1'b0;
                flag[s]   <= 1'b0;
            end else begin
                prev_q[s] <= stschg[s];
                flag[s]   <= (flag[s] & ~clr[s]) |
                             (stschg[s] & ~prev_q[s] & ~cfg[s].ring_en);
            end
        end
        assign ring_src[s] = stschg[s] & cfg[s].ring_en & cfg[s].pwr_ok;

        a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[s] && !clr[s]) |=> flag[s]);
        a_r10_ring_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag[s] && cfg[s].ring_en) |=> !flag[s]);
    end

    // Register the qualified ring-indicate request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_n <= 1'b1;
        else
            ring_n <= ~(ring_master & ~ring_inhibit & (|ring_src));
    end

    a_r9_ring_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ring_n |-> $past(ring_master && !ring_inhibit));
endmodule

// File: rtl/cir_route.sv
// Interrupt steering: maps each socket's active request onto PCI A, PCI B
// or one ISA line, ORs shared targets, and registers all active-low outputs
// including the power-management event.
module cir_route
    import card_irq_pkg::*;
#(
    parameter int NUM_SOCK = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SOCK-1:0]      req,
    input  sock_cfg_t [NUM_SOCK-1:0] cfg,
    input  logic                     isa_mode,
    input  logic [NUM_SOCK-1:0]      flag,
    output logic                     inta_n,
    output logic                     intb_n,
    output logic [ISA_LINES-1:0]     isa_irq_n,
    output logic                     pme_n
);
    logic                 hit_a, hit_b, hit_pme;
    logic [ISA_LINES-1:0] hit_isa;

    // Gather every socket's qualified request per target.
    always_comb begin
        hit_a   = 1'b0;
        hit_b   = 1'b0;
        hit_pme = 1'b0;
        hit_isa = '0;
        for (int s = 0; s < NUM_SOCK; s++) begin
            if (req[s]) begin
                case (cfg[s].route)
                    RT_PCIA: hit_a = 1'b1;
                    RT_PCIB: hit_b = 1'b1;
                    RT_ISA:  if (isa_mode) hit_isa[cfg[s].isa_sel] = 1'b1;
                    default: ;
                endcase
            end
            hit_pme = hit_pme | (flag[s] & cfg[s].wake_en);
        end
    end

    // Register the active-low outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inta_n    <= 1'b1;
            intb_n    <= 1'b1;
            isa_irq_n <= '1;
            pme_n     <= 1'b1;
        end else begin
            inta_n    <= ~hit_a;
            intb_n    <= ~hit_b;
            isa_irq_n <= ~hit_isa;
            pme_n     <= ~hit_pme;
        end
    end

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_chk
        a_r2_route_a: assert property (@(posedge clk) disable iff (!rst_n)
            (req[s] && cfg[s].route == RT_PCIA) |=> !inta_n);
        a_r2_route_b: assert property (@(posedge clk) disable iff (!rst_n)
            (req[s] && cfg[s].route == RT_PCIB) |=> !intb_n);
        a_r8_pme_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[s] && cfg[s].wake_en) |=> !pme_n);
    end
    a_r6_pci_only: assert property (@(posedge clk) disable iff (!rst_n)
        !isa_mode |=> (&isa_irq_n));
    a_r4_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (inta_n && intb_n && (&isa_irq_n)));
endmodule

// File: rtl/card_irq_router.sv
// Top: card interrupt steering router for NUM_SOCK sockets. Card interrupt
// inputs are active-low levels; all outputs are active-low and registered.
module card_irq_router
    import card_irq_pkg::*;
#(
    parameter int NUM_SOCK = 2,
    parameter int ADDR_W   = $clog2(NUM_SOCK + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SOCK-1:0]  card_irq_n,
    input  logic [NUM_SOCK-1:0]  stschg,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [CFG_W-1:0]     reg_wdata,
    output logic                 inta_n,
    output logic                 intb_n,
    output logic [ISA_LINES-1:0] isa_irq_n,
    output logic                 pme_n,
    output logic                 ring_n
);
    sock_cfg_t [NUM_SOCK-1:0] cfg;
    logic                     isa_mode, ring_master, ring_inhibit;
    logic [NUM_SOCK-1:0]      clr, flag;

    cir_regs #(.NUM_SOCK(NUM_SOCK), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cfg(cfg), .isa_mode(isa_mode),
        .ring_master(ring_master), .ring_inhibit(ring_inhibit), .clr(clr)
    );

    cir_status #(.NUM_SOCK(NUM_SOCK)) u_status (
        .clk(clk), .rst_n(rst_n), .stschg(stschg), .cfg(cfg), .clr(clr),
        .ring_master(ring_master), .ring_inhibit(ring_inhibit),
        .flag(flag), .ring_n(ring_n)
    );

    cir_route #(.NUM_SOCK(NUM_SOCK)) u_route (
        .clk(clk), .rst_n(rst_n), .req(~card_irq_n), .cfg(cfg),
        .isa_mode(isa_mode), .flag(flag), .inta_n(inta_n), .intb_n(intb_n),
        .isa_irq_n(isa_irq_n), .pme_n(pme_n)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (inta_n && intb_n && pme_n && ring_n && (&isa_irq_n)));
endmodule

// File: tb/tb_card_irq_router.sv
module tb_card_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  card_irq_n = 2'b11;
    logic [1:0]  stschg = 2'b00;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [8:0]  reg_wdata = '0;
    logic        inta_n, intb_n, pme_n, ring_n;
    logic [15:0] isa_irq_n;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    card_irq_router dut (
        .clk(clk), .rst_n(rst_n), .card_irq_n(card_irq_n), .stschg(stschg),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .inta_n(inta_n), .intb_n(intb_n), .isa_irq_n(isa_irq_n),
        .pme_n(pme_n), .ring_n(ring_n)
    );

    // Vector: r0[31:30] i0[29:26] r1[25:24] i1[23:20] irq_n[19:18] expA[17] expB[16] expISA[15:0]
    localparam logic [31:0] VEC [10] = '{
        {2'd1, 4'd0, 2'd0, 4'd0,  2'b10, 1'b0, 1'b1, 16'hffff}, // R2 A
        {2'd2, 4'd0, 2'd0, 4'd0,  2'b10, 1'b1, 1'b0, 16'hffff}, // R2 B
        {2'd3, 4'd5, 2'd0, 4'd0,  2'b10, 1'b1, 1'b1, 16'hffdf}, // R3 ISA5
        {2'd0, 4'd0, 2'd1, 4'd0,  2'b00, 1'b0, 1'b1, 16'hffff}, // R4 s0 off
        {2'd1, 4'd0, 2'd1, 4'd0,  2'b01, 1'b0, 1'b1, 16'hffff}, // R5 shared A
        {2'd1, 4'd0, 2'd1, 4'd0,  2'b11, 1'b1, 1'b1, 16'hffff}, // R2 release
        {2'd3, 4'd3, 2'd3, 4'd12, 2'b00, 1'b1, 1'b1, 16'heff7}, // R3 two lines
        {2'd3, 4'd7, 2'd3, 4'd7,  2'b01, 1'b1, 1'b1, 16'hff7f}, // R5 shared ISA
        {2'd0, 4'd0, 2'd0, 4'd0,  2'b00, 1'b1, 1'b1, 16'hffff}, // R4 both off
        {2'd1, 4'd0, 2'd2, 4'd0,  2'b00, 1'b0, 1'b0, 16'hffff}  // R2 A and B
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [8:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 outputs", {isa_irq_n, inta_n, intb_n, pme_n, ring_n}, {16'hffff, 4'b1111});

        wr(2'd2, 9'h001); // PCI+ISA mode
        for (int v = 0; v < 10; v++) begin
            wr(2'd0, {3'b000, VEC[v][29:26], VEC[v][31:30]});
            wr(2'd1, {3'b000, VEC[v][23:20], VEC[v][25:24]});
            card_irq_n = VEC[v][19:18];
            tick(1);
            check($sformatf("R2/R3/R4/R5 vec%0d", v),
                  {14'd0, inta_n, intb_n, isa_irq_n}, {14'd0, VEC[v][17:0]});
        end

        // R6: PCI-only mode suppresses ISA route
        wr(2'd0, {3'b000, 4'd5, 2'd3});
        wr(2'd1, 9'h000);
        card_irq_n = 2'b10;
        wr(2'd2, 9'h000);
        tick(1);
        check("R6 pci only", {inta_n, intb_n, isa_irq_n}, {2'b11, 16'hffff});
        card_irq_n = 2'b11;

        // R7/R8: sticky flag and event output
        wr(2'd0, 9'b001_0000_00); // wake enabled, route off
        check("R8 idle", {31'd0, pme_n}, 32'd1);
        stschg = 2'b01;
        tick(1);
        stschg = 2'b00;
        tick(1);
        check("R8 pme raised", {31'd0, pme_n}, 32'd0);
        tick(5);
        check("R7 flag held", {31'd0, pme_n}, 32'd0);
        wr(2'd3, 9'h000);
        tick(1);
        check("R7 write zero no clear", {31'd0, pme_n}, 32'd0);
        wr(2'd3, 9'h001);
        tick(1);
        check("R7 w1c clears", {31'd0, pme_n}, 32'd1);
        stschg = 2'b01;
        tick(2);
        stschg = 2'b00;
        check("R7 re-set", {31'd0, pme_n}, 32'd0);
        tick(1);
        // set and clear in the same cycle: set wins
        @(negedge clk);
        stschg = 2'b01; reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 9'h001;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; stschg = 2'b00;
        tick(1);
        check("R7 set wins", {31'd0, pme_n}, 32'd0);
        wr(2'd3, 9'h001);
        tick(1);
        check("R7 cleared again", {31'd0, pme_n}, 32'd1);

        // R9/R10: ring indicate on socket 1
        wr(2'd2, 9'h002);                   // ring master on, inhibit off
        wr(2'd1, 9'b111_0000_00);           // pwr, ring, wake
        stschg = 2'b10;
        tick(1);
        check("R9 ring active", {31'd0, ring_n}, 32'd0);
        tick(1);
        check("R10 no pme from ring socket", {31'd0, pme_n}, 32'd1);
        wr(2'd2, 9'h006);                   // inhibit set
        tick(1);
        check("R9 inhibit blocks", {31'd0, ring_n}, 32'd1);
        wr(2'd2, 9'h002);
        tick(1);
        check("R9 ring back", {31'd0, ring_n}, 32'd0);
        wr(2'd1, 9'b011_0000_00);           // power qualifier off
        tick(1);
        check("R9 power qualifier", {31'd0, ring_n}, 32'd1);
        wr(2'd2, 9'h000);
        wr(2'd1, 9'b111_0000_00);
        tick(1);
        check("R9 master off", {31'd0, ring_n}, 32'd1);
        stschg = 2'b00;
        tick(2);
        check("R10 pme still idle", {31'd0, pme_n}, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule